// File: doc/BRIEF.md
# Single-Cycle-Round Feistel Block Cipher Core

This core encrypts one 64-bit block through a sixteen-round Feistel network. It uses eighteen 32-bit round keys and four substitution tables, each 256 words of 32 bits. The keys and tables live in synchronous memories outside the core. The core drives their read addresses and their output-register clears, and it takes their registered read data back. Loading those memories and any key-schedule sequencing belong to the surrounding logic.

The round is retimed so that it costs one clock cycle. The core keeps the left half with its round key already mixed in. The key word for the next round is read one cycle early. The S-table addresses for the next round come straight from the value about to be written into the left register. The round-function output and the key word are folded in on every cycle with no selection logic. Where a term must not contribute, the core holds the relevant memory output register cleared, so that term reads as zero. S0 and S1 suit the two ports of one dual-port memory, and S2 and S3 suit the two ports of another. All four S ports share one clear line.

A start pulse with a plaintext begins an encryption. Eighteen cycles later a one-cycle done pulse marks the ciphertext on the output. The output then holds until the next accepted start.

Top module: `cfc_core`

## Requirements
- R1: Reset state. While reset is applied and after it is released with no start, `done_o` is 0 and `block_o` is all zeros. Both `sbox_zero_o` and `key_zero_o` are 1, and `key_addr_o` is 0.
- R2: Ciphertext. The ciphertext matches the plain Feistel cipher described here. Bits 63:32 form the left half and bits 31:0 the right half. For rounds i = 0..15, the left half is XORed with key i, the right half is XORed with F(left), and the halves are swapped. The swap after the last round is undone. Then the right half is XORed with key 16 and the left half with key 17.
- R3: Round function. F splits its 32-bit input into bytes a (bits 31:24), b, c and d (bits 7:0). It returns ((S0[a] + S1[b]) XOR S2[c]) + S3[d], with both additions modulo 2^32.
- R4: Latency. Call the cycle in which start is sampled cycle 0. `done_o` is high in cycle 19 only, which is 18 rising edges after the accepting edge, and `block_o` holds the ciphertext in that cycle.
- R5: Key reads. `key_addr_o` is k in cycle k for k = 0..17, and 0 in cycle 18. The key memory returns the word one cycle after the address.
- R6: S-table clears. `sbox_zero_o` is 1 whenever the core is idle, and in cycle 17 of a run. It is 0 in cycles 1 to 16 and in cycle 18.
- R7: A start that arrives while a run is in progress is ignored. The ciphertext and the done cycle of the run are unchanged.
- R8: Between done and the next accepted start, `block_o` keeps the ciphertext, whatever `block_i` does.
- R9: A new start may be given in the cycle where `done_o` is high. It is accepted and encrypted correctly, so one block completes every 19 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| block_i | input | 64 | Plaintext, left half in the upper 32 bits |
| block_o | output | 64 | Ciphertext register |
| done_o | output | 1 | One-cycle pulse when `block_o` is fresh |
| key_addr_o | output | 5 | Round-key memory read address |
| key_zero_o | output | 1 | Clear for the key memory output register |
| key_data_i | input | 32 | Registered round-key read data |
| sbox_zero_o | output | 1 | Clear shared by the four S-table output registers |
| sbox0_addr_o | output | 8 | S0 read address (byte a) |
| sbox1_addr_o | output | 8 | S1 read address (byte b) |
| sbox2_addr_o | output | 8 | S2 read address (byte c) |
| sbox3_addr_o | output | 8 | S3 read address (byte d) |
| sbox0_data_i | input | 32 | S0 registered read data |
| sbox1_data_i | input | 32 | S1 registered read data |
| sbox2_data_i | input | 32 | S2 registered read data |
| sbox3_data_i | input | 32 | S3 registered read data |

## Verification
A wrong value in either half register feeds the S-table addresses on the very next cycle. The error is then mixed through every later round, so it shows only at the done pulse, as a ciphertext that differs in roughly half its bits.

A fault in the step counter shows much sooner. It appears on `key_addr_o` or `sbox_zero_o` in the cycle the count goes wrong, or as a done pulse in the wrong cycle. The bench therefore checks the address and clear pins in every cycle of each run, in addition to the final ciphertext.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  // Control handed from the step sequencer to the half-word datapath.
  typedef struct packed {
    logic load;  // capture a new plaintext (halves stored crossed)
    logic adv;   // perform one retimed round
  } cfc_ctl_t;

  localparam int CFC_SBOXES = 4;

endpackage

// File: rtl/cfc_round_fn.sv
module cfc_round_fn #(
  parameter int HALF_W = 32
) (
  input  logic [HALF_W-1:0] s0_i,
  input  logic [HALF_W-1:0] s1_i,
  input  logic [HALF_W-1:0] s2_i,
  input  logic [HALF_W-1:0] s3_i,
  output logic [HALF_W-1:0] f_o
);

  logic [HALF_W-1:0] sum01;
  logic [HALF_W-1:0] mixed;

  // Wrapping adds: upper carries drop off the word.
  always_comb begin
    sum01 = s0_i + s1_i;
    mixed = sum01 ^ s2_i;
    f_o   = mixed + s3_i;
  end

endmodule

// File: rtl/cfc_seq.sv
module cfc_seq
  import cfc_pkg::*;
#(
  parameter int ROUNDS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  output cfc_ctl_t                      ctl_o,
  output logic [$clog2(ROUNDS+2)-1:0]   key_addr_o,
  output logic                          key_zero_o,
  output logic                          sbox_zero_o,
  output logic                          done_o
);

  localparam int STEPS = ROUNDS + 2;
  localparam int SW    = $clog2(STEPS + 1);
  localparam int KW    = $clog2(ROUNDS + 2);

  logic [SW-1:0] step_q, step_d;
  logic          done_q, done_d;
  logic          busy, accept, last_step;

  always_comb begin
    busy      = (step_q != '0);
    last_step = (step_q == SW'(STEPS));
    accept    = start_i && !busy;

    step_d = step_q;
    if (accept)         step_d = SW'(1);
    else if (last_step) step_d = '0;
    else if (busy)      step_d = step_q + SW'(1);

    done_d = last_step;

    ctl_o.load = accept;
    ctl_o.adv  = busy;

    // Key word k is requested in cycle k; the final step needs none.
    key_addr_o  = last_step ? '0 : KW'(step_q);
    key_zero_o  = (!busy && !start_i) || last_step;
    // Round function must read zero in step 1 (idle request) and in the
    // closing step where only the last key word is applied.
    sbox_zero_o = !busy || (step_q == SW'(STEPS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R4: done never lasts more than one cycle.
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: key address never leaves the key memory.
  assert_key_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_addr_o <= KW'(ROUNDS + 1));

  // R5: inside a run the key address walks up by one.
  assert_key_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_addr_o != '0 && key_addr_o != KW'(ROUNDS + 1)) |=>
      key_addr_o == $past(key_addr_o) + KW'(1));

  // R7: a start during a run never restarts the count.
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> step_q != SW'(1));

  // R6: the done cycle is idle, so the S clear is held.
  assert_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> sbox_zero_o);

endmodule

// File: rtl/cfc_dp.sv
module cfc_dp
  import cfc_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cfc_ctl_t              ctl_i,
  input  logic [2*HALF_W-1:0]   block_i,
  input  logic [HALF_W-1:0]     key_i,
  input  logic [HALF_W-1:0]     f_i,
  output logic [HALF_W-1:0]     mix_o,
  output logic [2*HALF_W-1:0]   block_o
);

  // x_q: left half with its key already folded in; r_q: right half.
  logic [HALF_W-1:0] x_q, x_d;
  logic [HALF_W-1:0] r_q, r_d;
  logic [HALF_W-1:0] mix;

  always_comb begin
    // All three XOR terms every cycle; cleared memories null them.
    mix = r_q ^ f_i ^ key_i;
    x_d = x_q;
    r_d = r_q;
    if (ctl_i.load) begin
      // Stored crossed so the first advance forms left ^ key0.
      x_d = block_i[HALF_W-1:0];
      r_d = block_i[2*HALF_W-1:HALF_W];
    end else if (ctl_i.adv) begin
      x_d = mix;
      r_d = x_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      r_q <= '0;
    end else begin
      x_q <= x_d;
      r_q <= r_d;
    end
  end

  assign mix_o   = mix;
  assign block_o = {x_q, r_q};

  // R8: with neither load nor advance the result register holds.
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.load && !ctl_i.adv) |=> $stable(block_o));

  // R2: an advance moves the keyed left half into the right register.
  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.adv |=> block_o[HALF_W-1:0] == $past(block_o[2*HALF_W-1:HALF_W]));

endmodule

// File: rtl/cfc_core.sv
module cfc_core
  import cfc_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ROUNDS = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [2*HALF_W-1:0]           block_i,
  output logic [2*HALF_W-1:0]           block_o,
  output logic                          done_o,
  output logic [$clog2(ROUNDS+2)-1:0]   key_addr_o,
  output logic                          key_zero_o,
  input  logic [HALF_W-1:0]             key_data_i,
  output logic                          sbox_zero_o,
  output logic [HALF_W/4-1:0]           sbox0_addr_o,
  output logic [HALF_W/4-1:0]           sbox1_addr_o,
  output logic [HALF_W/4-1:0]           sbox2_addr_o,
  output logic [HALF_W/4-1:0]           sbox3_addr_o,
  input  logic [HALF_W-1:0]             sbox0_data_i,
  input  logic [HALF_W-1:0]             sbox1_data_i,
  input  logic [HALF_W-1:0]             sbox2_data_i,
  input  logic [HALF_W-1:0]             sbox3_data_i
);

  localparam int BYTE_W = HALF_W / CFC_SBOXES;

  cfc_ctl_t          ctl;
  logic [HALF_W-1:0] f_val;
  logic [HALF_W-1:0] mix;
  logic [BYTE_W-1:0] saddr [CFC_SBOXES];

  cfc_seq #(.ROUNDS(ROUNDS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ctl_o       (ctl),
    .key_addr_o  (key_addr_o),
    .key_zero_o  (key_zero_o),
    .sbox_zero_o (sbox_zero_o),
    .done_o      (done_o)
  );

  cfc_round_fn #(.HALF_W(HALF_W)) u_fn (
    .s0_i (sbox0_data_i),
    .s1_i (sbox1_data_i),
    .s2_i (sbox2_data_i),
    .s3_i (sbox3_data_i),
    .f_o  (f_val)
  );

  cfc_dp #(.HALF_W(HALF_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_i   (ctl),
    .block_i (block_i),
    .key_i   (key_data_i),
    .f_i     (f_val),
    .mix_o   (mix),
    .block_o (block_o)
  );

  // Next round's table addresses come from the value entering the left
  // register; byte 0 is the most significant and indexes S0.
  for (genvar k = 0; k < CFC_SBOXES; k++) begin : g_saddr
    assign saddr[k] = mix[HALF_W-1-k*BYTE_W -: BYTE_W];
  end

  assign sbox0_addr_o = saddr[0];
  assign sbox1_addr_o = saddr[1];
  assign sbox2_addr_o = saddr[2];
  assign sbox3_addr_o = saddr[3];

  // R1: out of reset with no start, both memory clears are asserted.
  assert_idle_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !$past(start_i) && !done_o && sbox_zero_o && key_addr_o == '0)
      |-> key_zero_o);

endmodule

// File: tb/sim_cfc_core.sv
`timescale 1ns/1ps
module sim_cfc_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] blk_in;
  logic [63:0] blk_out;
  logic        done;
  logic [4:0]  kaddr;
  logic        kzero;
  logic [31:0] kq;
  logic        szero;
  logic [7:0]  sa0, sa1, sa2, sa3;
  logic [31:0] sq0, sq1, sq2, sq3;

  int total = 0;
  int bad   = 0;

  logic [31:0] pk [18];
  logic [31:0] sb [4][256];

  always #2 clk = ~clk;

  cfc_core u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .block_i(blk_in),
    .block_o(blk_out), .done_o(done),
    .key_addr_o(kaddr), .key_zero_o(kzero), .key_data_i(kq),
    .sbox_zero_o(szero),
    .sbox0_addr_o(sa0), .sbox1_addr_o(sa1), .sbox2_addr_o(sa2), .sbox3_addr_o(sa3),
    .sbox0_data_i(sq0), .sbox1_data_i(sq1), .sbox2_data_i(sq2), .sbox3_data_i(sq3)
  );

  // Behavioural synchronous memories with output-register clear.
  always @(posedge clk) begin
    kq  <= kzero ? 32'h0 : ((kaddr < 5'd18) ? pk[kaddr] : 32'h0);
    sq0 <= szero ? 32'h0 : sb[0][sa0];
    sq1 <= szero ? 32'h0 : sb[1][sa1];
    sq2 <= szero ? 32'h0 : sb[2][sa2];
    sq3 <= szero ? 32'h0 : sb[3][sa3];
  end

  function automatic logic [31:0] ref_f(input logic [31:0] x);
    return ((sb[0][x[31:24]] + sb[1][x[23:16]]) ^ sb[2][x[15:8]]) + sb[3][x[7:0]];
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] b);
    logic [31:0] l, r, t;
    l = b[63:32];
    r = b[31:0];
    for (int i = 0; i < 16; i++) begin
      l = l ^ pk[i];
      r = r ^ ref_f(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ pk[16];
    l = l ^ pk[17];
    return {l, r};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 18; i++) pk[i] = $urandom;
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 256; v++) sb[t][v] = $urandom;
  endtask

  // Called just after a negedge; leaves the bench at the negedge of the
  // done cycle (cycle 19) so a following call starts back-to-back.
  task automatic run(input logic [63:0] pt, input bit poke,
                     output logic [63:0] ct);
    bit key_ok = 1, sz_ok = 1, done_ok = 1;
    logic [63:0] k_act = 0, k_exp = 0;
    start  = 1'b1;
    blk_in = pt;
    #0.5;
    if (kaddr != 5'd0) begin key_ok = 0; k_act = 64'(kaddr); k_exp = 0; end
    for (int j = 1; j <= 19; j++) begin
      @(negedge clk);
      if (j == 1) begin start = 1'b0; blk_in = ~pt; end
      if (poke && j == 5) begin start = 1'b1; blk_in = pt ^ 64'h1234; end
      if (poke && j == 6) start = 1'b0;
      #0.5;
      if (j <= 18 && kaddr != ((j <= 17) ? 5'(j) : 5'd0)) begin
        key_ok = 0; k_act = 64'(kaddr); k_exp = (j <= 17) ? 64'(j) : 0;
      end
      if (szero != ((j == 17) || (j == 19))) sz_ok = 0;
      if (done != (j == 19)) done_ok = 0;
    end
    ct = blk_out;
    chk(key_ok,  "R5 key address sequence", k_act, k_exp);
    chk(sz_ok,   "R6 sbox clear timing", 64'(szero), 64'(1));
    chk(done_ok, "R4 done in cycle 19 only", 64'(done), 64'(1));
  endtask

  localparam logic [63:0] PT [6] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0001,
    64'hDEAD_BEEF_00C0_FFEE, 64'h5555_AAAA_3333_CCCC
  };

  logic finished = 1'b0;

  initial begin
    logic [63:0] ct, ct2, exp, exp2;
    rst_n  = 1'b0;
    start  = 1'b0;
    blk_in = '0;
    fill_random();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 1'b0,     "R1 done low",      64'(done),  0);
    chk(blk_out == 64'h0, "R1 block zero",    blk_out,    0);
    chk(szero == 1'b1,    "R1 sbox clear",    64'(szero), 1);
    chk(kzero == 1'b1,    "R1 key clear",     64'(kzero), 1);
    chk(kaddr == 5'd0,    "R1 key addr zero", 64'(kaddr), 0);

    // R2 table of plaintexts, tables refreshed every other row
    for (int n = 0; n < 6; n++) begin
      if (n % 2 == 1) fill_random();
      exp = ref_enc(PT[n]);
      run(PT[n], 1'b0, ct);
      chk(ct == exp, "R2 ciphertext", ct, exp);
      @(negedge clk);
    end

    // R3 byte order: tables make F the identity, keys zero
    for (int i = 0; i < 18; i++) pk[i] = 32'h0;
    for (int t = 0; t < 4; t++)
      for (int v = 0; v < 256; v++) sb[t][v] = 32'(v) << (8 * (3 - t));
    exp = ref_enc(64'h0102_0304_0506_0708);
    run(64'h0102_0304_0506_0708, 1'b0, ct);
    chk(ct == exp, "R3 identity round function", ct, exp);
    @(negedge clk);
    // R3: only one table live at a time exposes byte-to-table mapping
    for (int live = 0; live < 4; live++) begin
      fill_random();
      for (int t = 0; t < 4; t++)
        if (t != live) for (int v = 0; v < 256; v++) sb[t][v] = 32'h0;
      exp = ref_enc(64'hA5C3_1E77_0F9B_6D24);
      run(64'hA5C3_1E77_0F9B_6D24, 1'b0, ct);
      chk(ct == exp, "R3 single live table", ct, exp);
      @(negedge clk);
    end

    // R7 start during a run is ignored
    fill_random();
    exp = ref_enc(64'h1357_9BDF_2468_ACE0);
    run(64'h1357_9BDF_2468_ACE0, 1'b1, ct);
    chk(ct == exp, "R7 mid-run start ignored", ct, exp);

    // R8 result holds while idle and input wanders
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      blk_in = {$urandom, $urandom};
    end
    #0.5;
    chk(blk_out == exp, "R8 result held", blk_out, exp);
    @(negedge clk);

    // R9 back-to-back: second start in the done cycle
    exp  = ref_enc(64'hFEDC_BA98_7654_3210);
    exp2 = ref_enc(64'h0F0F_F0F0_3C3C_C3C3);
    run(64'hFEDC_BA98_7654_3210, 1'b0, ct);
    run(64'h0F0F_F0F0_3C3C_C3C3, 1'b0, ct2);
    chk(ct == exp,   "R9 first of pair",  ct,  exp);
    chk(ct2 == exp2, "R9 second of pair", ct2, exp2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule